// File: doc/BRIEF.md
# Power-Mode-Aware Capture Timer

This block is a free-running up-counter with a single input-capture channel. A small power-mode controller next to it decides when the counter may advance. In normal running and in the light sleep mode the counter steps once per clock. A capture pin whose active edge has the chosen polarity copies the count into a capture register and raises a flag. That flag, gated by an enable, forms the timer interrupt request. The interrupt can also pull the controller out of light sleep.

In the deep sleep mode the counter clock is treated as stopped. The count freezes, and a capture edge only arms a sticky detector. It raises no flag and does not wake the block. A wake-up request returns the block to running. The count then carries on from the frozen value, and any armed capture shows up in the same cycle as the flag plus the frozen count. A reset taken during deep sleep discards the armed capture and reloads the counter. A one-cycle clear strobe takes the place of software acknowledging the flag.

The block has no streaming data path, so every pin is a plain level or strobe and there is no back-pressure.

Top module: `lp_capture_timer`

## Requirements
- R1: While and after reset, `count_o` is 16'hFFFC, `capt_o` is 0, `cap_flag_o` and `timer_irq_o` are 0, and `mode_o` is 2'b00 (run). The mode encoding is 2'b00 run, 2'b01 light sleep, 2'b10 deep sleep.
- R2: Whenever `mode_o` is run or light sleep, `count_o` grows by one at each rising clock edge and wraps from 16'hFFFF to 16'h0000.
- R3: Mode changes take effect at the next edge. From run, `stop_req` selects deep sleep and wins over `wait_req`, which selects light sleep. Light sleep returns to run on `wake_irq` or on `timer_irq_o`. Deep sleep returns to run only on `wake_irq`.
- R4: While `mode_o` is deep sleep, `count_o` holds. After a wake-up it resumes from the held value and first steps at the edge after `mode_o` shows run again.
- R5: In run or light sleep, an active pin edge loads `capt_o` with the count and sets `cap_flag_o`. The pin passes through two synchronizing flip-flops, so both appear after the third rising edge following the pin change, and `capt_o` equals the `count_o` seen just before that edge. `cap_rise` 1 selects rising edges and 0 selects falling edges.
- R6: An active edge in deep sleep changes neither `cap_flag_o`, `capt_o` nor `mode_o`. At the edge that leaves deep sleep through `wake_irq`, `cap_flag_o` sets and `capt_o` takes the frozen count. Further edges in the same deep sleep have no extra effect.
- R7: A reset applied in deep sleep after an armed edge leaves `count_o` at 16'hFFFC, `mode_o` at run, and `cap_flag_o` and `capt_o` at 0. No flag appears afterwards.
- R8: `timer_irq_o` is high exactly when `cap_flag_o` and `cap_ie` are both high.
- R9: A `flag_clr` pulse clears `cap_flag_o` at the next edge. If a capture happens at the same edge, the flag stays set and `capt_o` updates.
- R10: A capture taken in light sleep with `cap_ie` high returns `mode_o` to run one edge after the flag rises.
- R11: A pin edge of the inactive polarity leaves `cap_flag_o` and `capt_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wait_req | input | 1 | Request for light sleep |
| stop_req | input | 1 | Request for deep sleep |
| wake_irq | input | 1 | External wake-up interrupt request |
| cap_pin | input | 1 | Asynchronous capture input |
| cap_rise | input | 1 | Capture polarity, 1 rising, 0 falling |
| cap_ie | input | 1 | Capture interrupt enable |
| flag_clr | input | 1 | Flag acknowledge strobe |
| count_o | output | 16 | Free-running count |
| capt_o | output | 16 | Captured count |
| cap_flag_o | output | 1 | Capture flag |
| timer_irq_o | output | 1 | Timer interrupt request |
| mode_o | output | 2 | Current power mode |

## Verification
The bench builds the block with its defaults: a 16-bit counter, a reset value of 16'hFFFC and two synchronizer stages. The reset value sits four steps below the wrap point, so the rollover to zero can be seen right after reset without long runs. The fixed two-stage synchronizer gives a known three-edge capture latency that the directed cases sample against. A seeded random phase then mixes sleep requests, wake-ups, pin toggles and clears, and predicts the mode and count cycle by cycle.

// File: rtl/lpct_pkg.sv
package lpct_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'b00,
    PM_WAIT = 2'b01,
    PM_STOP = 2'b10
  } pmode_t;
endpackage

// File: rtl/lpct_edge_sync.sv
module lpct_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic edge_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev;

  // shift register that retimes the asynchronous pin
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= 1'b0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[LAST];
  end

  always_comb begin
    if (rise_sel_i) edge_o = chain[LAST] & ~prev;
    else            edge_o = ~chain[LAST] & prev;
  end
endmodule

// File: rtl/lpct_pwr_ctrl.sv
module lpct_pwr_ctrl
  import lpct_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wait_req,
  input  logic   stop_req,
  input  logic   wake_irq,
  input  logic   timer_irq,
  output pmode_t mode,
  output logic   stop_exit
);
  pmode_t mode_nxt;

  always_comb begin
    mode_nxt = mode;
    unique case (mode)
      PM_RUN: begin
        if (stop_req)      mode_nxt = PM_STOP;
        else if (wait_req) mode_nxt = PM_WAIT;
      end
      PM_WAIT: begin
        if (wake_irq || timer_irq) mode_nxt = PM_RUN;
      end
      PM_STOP: begin
        if (wake_irq) mode_nxt = PM_RUN;
      end
      default: mode_nxt = PM_RUN;
    endcase
  end

  assign stop_exit = (mode == PM_STOP) && wake_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= PM_RUN;
    else        mode <= mode_nxt;
  end
endmodule

// File: rtl/lpct_counter.sv
module lpct_counter #(
  parameter int              CNT_W   = 16,
  parameter logic [CNT_W-1:0] RST_VAL = 16'hFFFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] STEP = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= RST_VAL;
    else if (tick_en) count <= count + STEP;
  end
endmodule

// File: rtl/lpct_capture.sv
module lpct_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stopped,
  input  logic             stop_exit,
  input  logic             edge_hit,
  input  logic             flag_clr,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capt,
  output logic             flag
);
  logic armed;
  logic load;

  // a live edge loads directly; an edge seen while stopped waits for wake-up
  assign load = (!stopped && edge_hit) || (stop_exit && (armed || edge_hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    armed <= 1'b0;
    else if (stop_exit)            armed <= 1'b0;
    else if (stopped && edge_hit)  armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    capt <= '0;
    else if (load) capt <= count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (load)     flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end
endmodule

// File: rtl/lp_capture_timer.sv
module lp_capture_timer
  import lpct_pkg::*;
#(
  parameter int               CNT_W       = 16,
  parameter logic [CNT_W-1:0] CNT_RST     = 16'hFFFC,
  parameter int               SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wait_req,
  input  logic             stop_req,
  input  logic             wake_irq,
  input  logic             cap_pin,
  input  logic             cap_rise,
  input  logic             cap_ie,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] capt_o,
  output logic             cap_flag_o,
  output logic             timer_irq_o,
  output logic [1:0]       mode_o
);
  pmode_t mode;
  logic   stop_exit;
  logic   edge_hit;
  logic   stopped;

  assign stopped     = (mode == PM_STOP);
  assign timer_irq_o = cap_flag_o & cap_ie;
  assign mode_o      = mode;

  lpct_pwr_ctrl u_pwr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wait_req  (wait_req),
    .stop_req  (stop_req),
    .wake_irq  (wake_irq),
    .timer_irq (timer_irq_o),
    .mode      (mode),
    .stop_exit (stop_exit)
  );

  lpct_counter #(.CNT_W(CNT_W), .RST_VAL(CNT_RST)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (!stopped),
    .count   (count_o)
  );

  lpct_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (cap_pin),
    .rise_sel_i (cap_rise),
    .edge_o     (edge_hit)
  );

  lpct_capture #(.CNT_W(CNT_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .stopped   (stopped),
    .stop_exit (stop_exit),
    .edge_hit  (edge_hit),
    .flag_clr  (flag_clr),
    .count     (count_o),
    .capt      (capt_o),
    .flag      (cap_flag_o)
  );
endmodule

// File: rtl/lpct_checker.sv
module lpct_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wake_irq,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] capt_o,
  input logic             cap_flag_o,
  input logic             timer_irq_o,
  input logic [1:0]       mode_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'b10) |=> (count_o == $past(count_o) + ONE));

  p_hold_in_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b10) |=> $stable(count_o));

  p_stop_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b10 && !wake_irq) |=> (mode_o == 2'b10));

  p_stop_capt_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b10 && !wake_irq) |=> ($stable(capt_o) && !$rose(cap_flag_o)));

  p_wait_irq_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b01 && timer_irq_o) |=> (mode_o == 2'b00));

  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timer_irq_o |-> cap_flag_o);
endmodule

bind lp_capture_timer lpct_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wake_irq    (wake_irq),
  .count_o     (count_o),
  .capt_o      (capt_o),
  .cap_flag_o  (cap_flag_o),
  .timer_irq_o (timer_irq_o),
  .mode_o      (mode_o)
);

// File: tb/sim_lp_capture_timer.sv
`timescale 1ns/1ps
module sim_lp_capture_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wait_req = 1'b0, stop_req = 1'b0, wake_irq = 1'b0;
  logic        cap_pin = 1'b0, cap_rise = 1'b1, cap_ie = 1'b0, flag_clr = 1'b0;
  logic [15:0] count_o, capt_o;
  logic        cap_flag_o, timer_irq_o;
  logic [1:0]  mode_o;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  lp_capture_timer u0 (
    .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .stop_req(stop_req),
    .wake_irq(wake_irq), .cap_pin(cap_pin), .cap_rise(cap_rise), .cap_ie(cap_ie),
    .flag_clr(flag_clr), .count_o(count_o), .capt_o(capt_o),
    .cap_flag_o(cap_flag_o), .timer_irq_o(timer_irq_o), .mode_o(mode_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cap_pin = 1'b0; wait_req = 0; stop_req = 0; wake_irq = 0; flag_clr = 0;
    tick(); tick();
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // reference mode step from the requirement R3
  function automatic logic [1:0] next_mode(input logic [1:0] m, input logic w,
      input logic s, input logic wk, input logic irq);
    case (m)
      2'b00:   return s ? 2'b10 : (w ? 2'b01 : 2'b00);
      2'b01:   return (wk || irq) ? 2'b00 : 2'b01;
      2'b10:   return wk ? 2'b00 : 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [15:0] next_count(input logic [15:0] c, input logic [1:0] m);
    return (m == 2'b10) ? c : c + 16'd1;
  endfunction

  // drive pin to level and return count seen before the capture edge
  task automatic pin_capture(input logic level, output logic [15:0] seen);
    cap_pin = level;
    tick(); tick();
    seen = count_o;
    tick();
  endtask

  initial begin
    logic [15:0] seen, frozen, old_capt, ec;
    logic [1:0]  em;
    @(negedge clk);
    // R1 reset state
    chk(count_o == 16'hFFFC, "R1 count", count_o, 16'hFFFC);
    chk(capt_o == 16'h0, "R1 capt", capt_o, 0);
    chk(!cap_flag_o && !timer_irq_o, "R1 flag/irq", {cap_flag_o, timer_irq_o}, 0);
    chk(mode_o == 2'b00, "R1 mode", mode_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 stepping and wrap
    chk(count_o == 16'hFFFD, "R2 step", count_o, 16'hFFFD);
    tick(); tick();
    chk(count_o == 16'hFFFF, "R2 top", count_o, 16'hFFFF);
    tick();
    chk(count_o == 16'h0000, "R2 wrap", count_o, 0);

    // R5 rising capture, R8 gating
    pin_capture(1'b1, seen);
    chk(cap_flag_o, "R5 flag", cap_flag_o, 1);
    chk(capt_o == seen, "R5 capt", capt_o, seen);
    chk(!timer_irq_o, "R8 masked", timer_irq_o, 0);
    cap_ie = 1'b1; #1;
    chk(timer_irq_o, "R8 enabled", timer_irq_o, 1);
    @(negedge clk);

    // R9 clear together with capture: capture wins
    cap_pin = 1'b0; tick(); tick(); tick();
    cap_pin = 1'b1; tick(); tick();
    seen = count_o; flag_clr = 1'b1; tick(); flag_clr = 1'b0;
    chk(cap_flag_o, "R9 capture wins", cap_flag_o, 1);
    chk(capt_o == seen, "R9 capt", capt_o, seen);
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;
    chk(!cap_flag_o, "R9 clear", cap_flag_o, 0);

    // R11 falling edge with rising polarity ignored
    old_capt = capt_o;
    cap_pin = 1'b0; tick(); tick(); tick(); tick();
    chk(!cap_flag_o && capt_o == old_capt, "R11 ignored", capt_o, old_capt);

    // R5 falling polarity
    cap_pin = 1'b1; tick(); tick(); tick(); tick();
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;
    cap_rise = 1'b0;
    pin_capture(1'b0, seen);
    chk(cap_flag_o && capt_o == seen, "R5 falling", capt_o, seen);
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;
    cap_rise = 1'b1;

    // R3 wait entry and wake exit, R2 counting in wait
    wait_req = 1'b1; tick(); wait_req = 1'b0;
    chk(mode_o == 2'b01, "R3 wait entry", mode_o, 1);
    seen = count_o; tick();
    chk(count_o == seen + 16'd1, "R2 wait count", count_o, seen + 16'd1);
    wake_irq = 1'b1; tick(); wake_irq = 1'b0;
    chk(mode_o == 2'b00, "R3 wait wake", mode_o, 0);

    // R10 capture in wait brings mode back to run
    wait_req = 1'b1; tick(); wait_req = 1'b0;
    pin_capture(1'b1, seen);
    chk(mode_o == 2'b01 && cap_flag_o && capt_o == seen, "R10 capture in wait",
        capt_o, seen);
    tick();
    chk(mode_o == 2'b00, "R10 exit", mode_o, 0);
    cap_pin = 1'b0; tick(); tick(); tick();
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;

    // R3 stop priority, R4 freeze, R6 armed capture
    wait_req = 1'b1; stop_req = 1'b1; tick(); wait_req = 1'b0; stop_req = 1'b0;
    chk(mode_o == 2'b10, "R3 stop wins", mode_o, 2);
    frozen = count_o; old_capt = capt_o;
    tick(); tick(); tick();
    chk(count_o == frozen, "R4 frozen", count_o, frozen);
    cap_pin = 1'b1; tick(); tick(); tick(); tick();
    cap_pin = 1'b0; tick(); tick(); tick();
    cap_pin = 1'b1; tick(); tick(); tick();
    chk(mode_o == 2'b10, "R6 no wake", mode_o, 2);
    chk(!cap_flag_o && capt_o == old_capt, "R6 no flag in stop", capt_o, old_capt);
    chk(count_o == frozen, "R4 still frozen", count_o, frozen);
    wake_irq = 1'b1; tick(); wake_irq = 1'b0;
    chk(mode_o == 2'b00, "R3 stop wake", mode_o, 0);
    chk(cap_flag_o && capt_o == frozen, "R6 capture at wake", capt_o, frozen);
    chk(count_o == frozen, "R4 resume point", count_o, frozen);
    tick();
    chk(count_o == frozen + 16'd1, "R4 resumed", count_o, frozen + 16'd1);
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;
    chk(!cap_flag_o, "R6 single flag", cap_flag_o, 0);

    // R7 reset exit from stop discards armed edge
    cap_pin = 1'b0; tick(); tick(); tick();
    stop_req = 1'b1; tick(); stop_req = 1'b0;
    cap_pin = 1'b1; tick(); tick(); tick(); tick();
    do_reset();
    chk(count_o == 16'hFFFD && mode_o == 2'b00, "R7 counter", count_o, 16'hFFFD);
    chk(!cap_flag_o && capt_o == 16'h0, "R7 no capture", capt_o, 0);
    tick(); tick(); tick();
    chk(!cap_flag_o, "R7 no late flag", cap_flag_o, 0);

    // seeded random phase: mode and count predicted each cycle (R2, R3, R4)
    void'($urandom(32'd4242));
    do_reset();
    em = 2'b00; ec = 16'hFFFD;
    for (int i = 0; i < 3000; i++) begin
      chk(mode_o == em, "R3 random mode", mode_o, em);
      chk(count_o == ec, "R2 random count", count_o, ec);
      wait_req = ($urandom % 10) == 0;
      stop_req = ($urandom % 20) == 0;
      wake_irq = ($urandom % 12) == 0;
      flag_clr = ($urandom % 5) == 0;
      cap_ie   = ($urandom % 2) == 0;
      if (($urandom % 3) == 0) cap_pin = ~cap_pin;
      #0.5;
      ec = next_count(ec, em);
      em = next_mode(em, wait_req, stop_req, wake_irq, timer_irq_o);
      tick();
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end
endmodule